// File: doc/BRIEF.md
# FIFO Fill Tracker and Transfer Scheduler

This block sits beside a byte-wide FIFO device whose own status is limited to coarse flags (empty, half, full). It rebuilds the exact number of stored bytes from two sources: a write strobe that adds one byte, and a completion pulse from the host-bus engine that removes the size of the transfer just finished. From that count it raises a mostly-full flag at a level set on an input pin. The sender upstream uses this flag to stop early, so bytes still in flight after the stop are absorbed by the remaining headroom.

The same count decides how the buffer is drained. When the scheduler is idle and holds at least 64 bytes, it offers a 64-byte burst. When it holds between 4 and 63 bytes, it offers a single 4-byte transfer. Below 4 bytes it offers nothing. Offers use a valid/ready handshake toward the bus engine, and the block becomes bus master for either size. Once an offer is taken, no further offer is made until the engine reports completion. The completion also removes the transfer's bytes from the count.

Back-pressure rules for the offer channel: `req_valid` and `req_big` stay constant until `req_ready` is seen high. The offer is taken on the first clock edge where both `req_valid` and `req_ready` are high. After that, `req_valid` stays low until the cycle following `xfer_done`. `xfer_done` is ignored unless a taken offer is outstanding. The write side has no ready signal: a write strobe arriving while the count is at capacity is dropped.

Top module: `fifo_burst_tracker`

## Requirements
- R1: After reset, `occ_count` is 0, `req_valid` is 0 and `mostly_full` is 0 (given a nonzero `mf_level`).
- R2: Each cycle with `wr_stb` high adds one to the count, except at capacity (8192), where the strobe is dropped and the count stays 8192.
- R3: `occ_count` shows the registered byte count. It changes on the clock edge that samples the strobe or the completion.
- R4: `mostly_full` is 1 exactly when `occ_count` is greater than or equal to `mf_level`.
- R5: An offer decided while the count is 64 or more has `req_big` = 1, meaning a 64-byte burst.
- R6: An offer decided while the count is from 4 to 63 has `req_big` = 0, meaning a single 4-byte transfer.
- R7: While the count is below 4, no offer is raised.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_big` keeps its value.
- R9: After an offer is taken, `req_valid` stays low until `xfer_done`. On `xfer_done` the count drops by 64 or 4 according to the taken size. The next offer is decided one cycle later from the updated count.
- R10: A write strobe and `xfer_done` in the same cycle change the count by plus one minus the transfer size.
- R11: The count is 0 exactly when `dev_empty` is high, and 8192 exactly when `dev_full` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One byte written into the FIFO this cycle |
| dev_empty | input | 1 | FIFO device empty flag |
| dev_full | input | 1 | FIFO device full flag |
| mf_level | input | 14 | Count at or above which mostly-full is raised |
| req_ready | input | 1 | Bus engine takes the current offer |
| xfer_done | input | 1 | Bus engine finished the taken transfer |
| req_valid | output | 1 | A transfer offer is pending |
| req_big | output | 1 | 1 = 64-byte burst, 0 = 4-byte single |
| mostly_full | output | 1 | Count has reached `mf_level` |
| occ_count | output | 14 | Exact stored byte count, 0 to 8192 |

## Verification
The assertions assume that the device flags agree with the true fill level. `dev_empty` and `dev_full` must settle after each edge to the count that edge produced. They also assume `xfer_done` is pulsed only for a transfer that was actually taken. The stimulus meets both assumptions by deriving the flags from the bench's own byte model at every falling edge. It raises `xfer_done` only after it has completed a handshake. Write strobes beyond capacity are driven on purpose, because the block is required to drop them.

// File: rtl/fbt_pkg.sv
`timescale 1ns/1ps
package fbt_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_OFFER = 2'd1,
    SCH_WAIT  = 2'd2
  } sch_state_e;
endpackage

// File: rtl/fbt_occ_counter.sv
`timescale 1ns/1ps
module fbt_occ_counter #(
  parameter int DEPTH  = 8192,
  parameter int BURST  = 64,
  parameter int SINGLE = 4,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          retire,
  input  logic          retire_big,
  input  logic          dev_empty,
  input  logic          dev_full,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);
  localparam logic [CW-1:0] BIGN = CW'(BURST);
  localparam logic [CW-1:0] SMLN = CW'(SINGLE);

  logic          wr_ok;
  logic [CW-1:0] dec;

  assign wr_ok = wr_stb && (count != CAP);

  always_comb begin
    dec = '0;
    if (retire) dec = retire_big ? BIGN : SMLN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CW'(wr_ok) - dec;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CAP && wr_stb && !retire) |=> count == CAP);
  a_r11_empty_match: assert property (@(posedge clk) disable iff (!rst_n)
    dev_empty == (count == '0));
  a_r11_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    dev_full == (count == CAP));
endmodule

// File: rtl/fbt_level_cmp.sv
`timescale 1ns/1ps
module fbt_level_cmp #(
  parameter int CW = 14
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  output logic          above
);
  assign above = (count >= level);
endmodule

// File: rtl/fbt_burst_sched.sv
`timescale 1ns/1ps
module fbt_burst_sched
  import fbt_pkg::*;
#(
  parameter int BURST  = 64,
  parameter int SINGLE = 4,
  parameter int CW     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          req_ready,
  input  logic          xfer_done,
  output logic          req_valid,
  output logic          req_big,
  output logic          retire,
  output logic          retire_big
);
  localparam logic [CW-1:0] BIGN = CW'(BURST);
  localparam logic [CW-1:0] SMLN = CW'(SINGLE);

  sch_state_e state;
  logic       big_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SCH_IDLE;
      big_q <= 1'b0;
    end else begin
      unique case (state)
        SCH_IDLE: if (count >= SMLN) begin
          state <= SCH_OFFER;
          big_q <= (count >= BIGN);
        end
        SCH_OFFER: if (req_ready) state <= SCH_WAIT;
        SCH_WAIT:  if (xfer_done) state <= SCH_IDLE;
        default:   state <= SCH_IDLE;
      endcase
    end
  end

  assign req_valid  = (state == SCH_OFFER);
  assign req_big    = big_q;
  assign retire     = (state == SCH_WAIT) && xfer_done;
  assign retire_big = big_q;

  a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_big)));
  a_r7_min_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(count) >= SMLN);
  a_r5_burst_pick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && $past(count) >= BIGN) |-> req_big);
  a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && $past(count) < BIGN) |-> !req_big);
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SCH_WAIT && !xfer_done) |=> !req_valid);
endmodule

// File: rtl/fifo_burst_tracker.sv
`timescale 1ns/1ps
module fifo_burst_tracker #(
  parameter int DEPTH  = 8192,
  parameter int BURST  = 64,
  parameter int SINGLE = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          dev_empty,
  input  logic          dev_full,
  input  logic [CW-1:0] mf_level,
  input  logic          req_ready,
  input  logic          xfer_done,
  output logic          req_valid,
  output logic          req_big,
  output logic          mostly_full,
  output logic [CW-1:0] occ_count
);
  logic retire;
  logic retire_big;

  fbt_occ_counter #(.DEPTH(DEPTH), .BURST(BURST), .SINGLE(SINGLE), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .retire(retire), .retire_big(retire_big),
    .dev_empty(dev_empty), .dev_full(dev_full),
    .count(occ_count)
  );

  fbt_level_cmp #(.CW(CW)) u_lvl (
    .count(occ_count), .level(mf_level), .above(mostly_full)
  );

  fbt_burst_sched #(.BURST(BURST), .SINGLE(SINGLE), .CW(CW)) u_sch (
    .clk(clk), .rst_n(rst_n), .count(occ_count),
    .req_ready(req_ready), .xfer_done(xfer_done),
    .req_valid(req_valid), .req_big(req_big),
    .retire(retire), .retire_big(retire_big)
  );
endmodule

// File: tb/tb_fifo_burst_tracker.sv
`timescale 1ns/1ps
module tb_fifo_burst_tracker;
  localparam int DEPTH = 8192;
  localparam int NV = 9;
  localparam int VN  [NV] = '{100, 0, 28, 8, 4, 63, 1, 200, 0};
  localparam int VBIG[NV] = '{1,   0, 0,  1, 0, 0,  0, 1,   1};
  localparam int VCNT[NV] = '{100, 36, 60, 64, 4, 63, 60, 256, 192};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_stb = 0;
  logic        dev_empty = 1;
  logic        dev_full = 0;
  logic [13:0] mf_level = 14'd8128;
  logic        req_ready = 0;
  logic        xfer_done = 0;
  logic        req_valid;
  logic        req_big;
  logic        mostly_full;
  logic [13:0] occ_count;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  int cur_sz = 4;

  fifo_burst_tracker dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .dev_empty(dev_empty), .dev_full(dev_full), .mf_level(mf_level),
    .req_ready(req_ready), .xfer_done(xfer_done),
    .req_valid(req_valid), .req_big(req_big),
    .mostly_full(mostly_full), .occ_count(occ_count)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_flags();
    dev_empty = (m_cnt == 0);
    dev_full  = (m_cnt == DEPTH);
  endtask

  task automatic push(int n);
    if (n > 0) begin
      wr_stb = 1;
      for (int j = 0; j < n; j++) begin
        @(negedge clk);
        if (m_cnt < DEPTH) m_cnt = m_cnt + 1;
        set_flags();
      end
      wr_stb = 0;
    end
  endtask

  task automatic take_offer();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk("R9 valid low after take", int'(req_valid), 0);
  endtask

  task automatic finish_xfer();
    xfer_done = 1;
    @(negedge clk);
    m_cnt = m_cnt - cur_sz;
    set_flags();
    xfer_done = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_flags();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", int'(occ_count), 0);
    chk("R1 valid", int'(req_valid), 0);
    chk("R1 mostly_full", int'(mostly_full), 0);

    push(4);
    @(negedge clk);
    chk("R6 first offer valid", int'(req_valid), 1);
    chk("R6 first offer small", int'(req_big), 0);
    chk("R3 count", int'(occ_count), 4);
    cur_sz = 4;

    for (int i = 0; i < NV; i++) begin
      take_offer();
      push(VN[i]);
      finish_xfer();
      chk("R9 count after done", int'(occ_count), VCNT[i]);
      chk("R3 count model", int'(occ_count), m_cnt);
      chk("R5 R6 offer valid", int'(req_valid), 1);
      chk(VBIG[i] != 0 ? "R5 burst size" : "R6 single size", int'(req_big), VBIG[i]);
      cur_sz = (VBIG[i] != 0) ? 64 : 4;
    end

    // R10: write and completion in the same cycle
    take_offer();
    wr_stb = 1;
    xfer_done = 1;
    @(negedge clk);
    m_cnt = m_cnt + 1 - cur_sz;
    set_flags();
    wr_stb = 0;
    xfer_done = 0;
    @(negedge clk);
    chk("R10 count", int'(occ_count), 129);
    chk("R10 offer big", int'(req_big), 1);
    cur_sz = 64;

    // R8: offer held under back-pressure, size stable while bytes arrive
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 valid held", int'(req_valid), 1);
      chk("R8 size held", int'(req_big), 1);
    end
    push(2);
    chk("R8 size held after writes", int'(req_big), 1);
    chk("R2 count", int'(occ_count), 131);

    // R9: nothing new while outstanding
    take_offer();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 no overlap", int'(req_valid), 0);
    end
    finish_xfer();
    chk("R9 count 67", int'(occ_count), 67);
    chk("R5 burst at 67", int'(req_big), 1);

    // R7: below minimum
    take_offer();
    finish_xfer();
    chk("R7 count 3", int'(occ_count), 3);
    chk("R7 no offer", int'(req_valid), 0);
    repeat (3) @(negedge clk);
    chk("R7 still no offer", int'(req_valid), 0);
    push(1);
    @(negedge clk);
    chk("R6 offer at 4", int'(req_valid), 1);
    chk("R6 small at 4", int'(req_big), 0);
    cur_sz = 4;

    // R4 and R2 at the top of the range
    take_offer();
    push(8123);
    chk("R4 below level", int'(mostly_full), 0);
    push(1);
    chk("R4 at level", int'(mostly_full), 1);
    push(64);
    chk("R2 reach capacity", int'(occ_count), DEPTH);
    push(5);
    chk("R2 drop at capacity", int'(occ_count), DEPTH);
    finish_xfer();
    chk("R9 count after full", int'(occ_count), 8188);
    chk("R5 burst after full", int'(req_big), 1);
    mf_level = 14'd8189;
    @(negedge clk);
    chk("R4 level above count", int'(mostly_full), 0);
    mf_level = 14'd100;
    @(negedge clk);
    chk("R4 level lowered", int'(mostly_full), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule